// File: doc/BRIEF.md
# EEPROM Write with Acknowledge-Polled Completion

This block is a master-side sequencer that writes one byte to a serial EEPROM over I2C and then finds out when the device has finished its internal programming cycle. It does not wait a fixed time for that cycle. It keeps addressing the device until the device answers with an acknowledge. The sequencer does not move SCL or SDA itself. It drives a command interface to a lower-level I2C byte engine, which takes three commands (issue a start condition, shift one byte out and return the ACK bit, issue a stop condition) and reports completion with a one-cycle strobe.

A request captures the 7-bit device address, the memory address, the data byte, a poll limit and a bus-hold choice. The block sends the write frame and ends it with a stop, which starts the device's program cycle. Polling then begins in the very next cycle. Each poll is a start followed by the control byte with the read/write bit at 0. A poll that is not acknowledged is closed with a stop and tried again. When a poll is acknowledged, the block either issues a stop or leaves the bus owned for a follow-on transfer, as the hold choice selects. If the device is never ready, a poll limit ends the loop with a timeout flag.

Top module: `wr_ack_poll_seq`

## Requirements
- R1: After reset, busy, done, cmd_valid, timeout_err, nack_err and bus_kept are all 0.
- R2: A request accepted while idle produces this command sequence: start, control byte {dev_addr, 1'b0}, the memory address bytes most significant first, the data byte, and then a stop. Command encodings on cmd_op are 0 = start, 1 = send byte, 2 = stop.
- R3: In the cycle right after the byte engine completes the write-ending stop, cmd_valid is 1 with cmd_op = start.
- R4: Each poll is a start followed by a send of {dev_addr, 1'b0}, so bit 0 (read/write) is 0.
- R5: A poll answered with bm_nack = 1 is followed by a stop, and then by a new poll start.
- R6: An acknowledged poll with hold_bus = 0 is followed by a stop before done, and bus_kept is 0. With hold_bus = 1, done follows the acknowledged control byte with no stop, and bus_kept is 1.
- R7: With max_polls = N > 0, after N unacknowledged polls (each closed by its stop) the block finishes with timeout_err = 1. A poll acknowledged on attempt N still succeeds. max_polls = 0 means there is no limit.
- R8: If any byte of the write frame is answered with bm_nack = 1, the block issues a stop, finishes with nack_err = 1 and sends no polls.
- R9: done is a one-cycle pulse in the cycle after the byte engine completes the last command. timeout_err, nack_err and bus_kept keep their values from that point until the next request is accepted, and then clear.
- R10: A req asserted while busy is ignored. The running sequence and its captured fields do not change.
- R11: While cmd_valid is 1 and bm_done is 0, cmd_valid, cmd_op and cmd_byte hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req | input | 1 | Start a write-and-poll operation (accepted only when idle) |
| dev_addr | input | 7 | 7-bit device address |
| mem_addr | input | ADDR_BYTES*8 | Memory address, sent most significant byte first |
| wr_data | input | 8 | Data byte to write |
| max_polls | input | CNT_W | Limit on unacknowledged polls; 0 means no limit |
| hold_bus | input | 1 | 1: keep the bus after a successful poll (no stop) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Poll limit reached without acknowledge |
| nack_err | output | 1 | A write-frame byte was not acknowledged |
| bus_kept | output | 1 | The bus was left owned after success |
| cmd_valid | output | 1 | Command presented to the byte engine |
| cmd_op | output | 2 | 0 start, 1 send byte, 2 stop |
| cmd_byte | output | 8 | Byte to send when cmd_op = 1 |
| bm_done | input | 1 | Byte engine completed the presented command |
| bm_nack | input | 1 | With bm_done after a send: the ACK bit read 1 |

## Verification
The bench runs a byte engine and device model with several completion latencies and compares every command the block issues against the sequence expected from the requirements. It looks for the following failures. A design that waits a cycle before polling, or that polls with a repeated start and no stop, breaks the expected order. A poll counter that is off by one times out a poll that acknowledges on the limit attempt, or allows one poll too many. A design that treats max_polls = 0 as a limit of zero times out at once. A design that keeps polling after a write-frame NACK, sends a stop when the bus should be held, leaves error flags set into the next request, or takes in a request while busy shows up as a command mismatch or a flag mismatch at done.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_STOP  = 2'd2
  } bm_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WSTART,
    S_WSEND,
    S_WSTOP,
    S_PSTART,
    S_PCTRL,
    S_PSTOP,
    S_FSTOP,
    S_ASTOP
  } seq_state_e;
endpackage

// File: rtl/ackpoll_rst_sync.sv
module ackpoll_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/ackpoll_frame_sel.sv
module ackpoll_frame_sel #(
  parameter int ADDR_BYTES = 2,
  parameter int IDX_W      = 3
) (
  input  logic [6:0]              dev_addr,
  input  logic [ADDR_BYTES*8-1:0] mem_addr,
  input  logic [7:0]              data,
  input  logic [IDX_W-1:0]        idx,
  output logic [7:0]              byte_o,
  output logic                    last_o
);
  localparam int NB = ADDR_BYTES + 2;

  logic [7:0] frame [NB];

  assign frame[0]    = {dev_addr, 1'b0};
  assign frame[NB-1] = data;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign frame[g+1] = mem_addr[(ADDR_BYTES-1-g)*8 +: 8];
  end

  always_comb begin
    byte_o = frame[0];
    for (int i = 0; i < NB; i++) begin
      if (idx == IDX_W'(i)) byte_o = frame[i];
    end
  end

  assign last_o = (idx == IDX_W'(NB-1));
endmodule

// File: rtl/ackpoll_ctr.sv
module ackpoll_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;

  always_comb begin
    count_en = clr | inc;
    count_d  = clr ? '0 : count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign hit = (limit != '0) && (count_q == limit);

  // R7: once the limit is reached the sequencer must not count another poll
  p_no_poll_past_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |-> !inc);
endmodule

// File: rtl/wr_ack_poll_seq.sv
module wr_ack_poll_seq
  import ackpoll_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int CNT_W      = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic [6:0]              dev_addr,
  input  logic [ADDR_BYTES*8-1:0] mem_addr,
  input  logic [7:0]              wr_data,
  input  logic [CNT_W-1:0]        max_polls,
  input  logic                    hold_bus,
  output logic                    busy,
  output logic                    done,
  output logic                    timeout_err,
  output logic                    nack_err,
  output logic                    bus_kept,
  output logic                    cmd_valid,
  output logic [1:0]              cmd_op,
  output logic [7:0]              cmd_byte,
  input  logic                    bm_done,
  input  logic                    bm_nack
);
  localparam int NB    = ADDR_BYTES + 2;
  localparam int IDX_W = $clog2(NB + 1);
  localparam int AW    = ADDR_BYTES * 8;

  logic rst_sync_n;

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [6:0]       dev_q;
  logic [AW-1:0]    addr_q;
  logic [7:0]       data_q;
  logic [CNT_W-1:0] lim_q;
  logic             hold_q;
  logic             done_q, done_d;
  logic             to_q, to_d, nk_q, nk_d, kept_q, kept_d;
  logic             accept, ctr_clr, ctr_inc, ctr_hit;
  logic             valid_c;
  bm_op_e           op_c;
  logic [7:0]       byte_c, frame_byte;
  logic             frame_last;

  ackpoll_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  ackpoll_frame_sel #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_frame (
    .dev_addr (dev_q),
    .mem_addr (addr_q),
    .data     (data_q),
    .idx      (idx_q),
    .byte_o   (frame_byte),
    .last_o   (frame_last)
  );

  ackpoll_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (ctr_clr),
    .inc   (ctr_inc),
    .limit (lim_q),
    .hit   (ctr_hit)
  );

  // next-state and command decode
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    to_d    = to_q;
    nk_d    = nk_q;
    kept_d  = kept_q;
    accept  = 1'b0;
    ctr_clr = 1'b0;
    ctr_inc = 1'b0;
    valid_c = 1'b1;
    op_c    = OP_STOP;
    byte_c  = frame_byte;
    unique case (state_q)
      S_IDLE: begin
        valid_c = 1'b0;
        if (req) begin
          accept  = 1'b1;
          ctr_clr = 1'b1;
          to_d    = 1'b0;
          nk_d    = 1'b0;
          kept_d  = 1'b0;
          idx_d   = '0;
          state_d = S_WSTART;
        end
      end
      S_WSTART: begin
        op_c = OP_START;
        if (bm_done) state_d = S_WSEND;
      end
      S_WSEND: begin
        op_c = OP_SEND;
        if (bm_done) begin
          if (bm_nack)         state_d = S_ASTOP;
          else if (frame_last) state_d = S_WSTOP;
          else                 idx_d   = idx_q + IDX_W'(1);
        end
      end
      S_WSTOP: begin
        if (bm_done) state_d = S_PSTART;
      end
      S_PSTART: begin
        op_c = OP_START;
        if (bm_done) state_d = S_PCTRL;
      end
      S_PCTRL: begin
        op_c   = OP_SEND;
        byte_c = {dev_q, 1'b0};
        if (bm_done) begin
          if (bm_nack) begin
            ctr_inc = 1'b1;
            state_d = S_PSTOP;
          end else if (hold_q) begin
            kept_d  = 1'b1;
            done_d  = 1'b1;
            state_d = S_IDLE;
          end else begin
            state_d = S_FSTOP;
          end
        end
      end
      S_PSTOP: begin
        if (bm_done) begin
          if (ctr_hit) begin
            to_d    = 1'b1;
            done_d  = 1'b1;
            state_d = S_IDLE;
          end else begin
            state_d = S_PSTART;
          end
        end
      end
      S_FSTOP: begin
        if (bm_done) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_ASTOP: begin
        if (bm_done) begin
          nk_d    = 1'b1;
          done_d  = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: begin
        valid_c = 1'b0;
        state_d = S_IDLE;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
      nk_q    <= 1'b0;
      kept_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      to_q    <= to_d;
      nk_q    <= nk_d;
      kept_q  <= kept_d;
    end
  end

  // request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dev_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      lim_q  <= '0;
      hold_q <= 1'b0;
    end else if (accept) begin
      dev_q  <= dev_addr;
      addr_q <= mem_addr;
      data_q <= wr_data;
      lim_q  <= max_polls;
      hold_q <= hold_bus;
    end
  end

  assign busy        = (state_q != S_IDLE);
  assign done        = done_q;
  assign timeout_err = to_q;
  assign nack_err    = nk_q;
  assign bus_kept    = kept_q;
  assign cmd_valid   = valid_c;
  assign cmd_op      = op_c;
  assign cmd_byte    = byte_c;

  // R3: polling starts in the cycle right after the write-ending stop
  p_poll_immediate_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == S_WSTOP && bm_done) |=> (cmd_valid && cmd_op == 2'd0));

  // R5: an unacknowledged poll is closed by a stop
  p_nack_then_stop_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == S_PCTRL && bm_done && bm_nack) |=> (cmd_valid && cmd_op == 2'd2));

  // R7: a timeout flag only appears together with completion
  p_timeout_at_done_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(timeout_err) |-> done);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  // R11: a presented command is held until the engine completes it
  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && !bm_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

  // R10: a request while busy leaves the captured fields untouched
  p_busy_ignores_req_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && req) |=> ($stable(addr_q) && $stable(data_q) && $stable(lim_q)));
endmodule

// File: tb/tb_wr_ack_poll_seq.sv
module tb_wr_ack_poll_seq;
  localparam int ADDR_BYTES = 2;
  localparam int CNT_W      = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [6:0]  dev_addr = '0;
  logic [15:0] mem_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  max_polls = '0;
  logic        hold_bus = 1'b0;
  logic        busy, done, timeout_err, nack_err, bus_kept;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_byte;
  logic        bm_done = 1'b0;
  logic        bm_nack = 1'b0;

  always #4 clk = ~clk;

  wr_ack_poll_seq #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .dev_addr(dev_addr),
    .mem_addr(mem_addr), .wr_data(wr_data), .max_polls(max_polls),
    .hold_bus(hold_bus), .busy(busy), .done(done),
    .timeout_err(timeout_err), .nack_err(nack_err), .bus_kept(bus_kept),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .bm_done(bm_done), .bm_nack(bm_nack)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // expected command stream: {op[1:0], byte[7:0]}
  logic [9:0] expq[$];
  int  lat_g = 1, np_g = 0, wn_g = -1;
  int  wcnt = 0, wsend_n = 0, poll_n = 0;
  bit  in_poll = 0, final_armed = 0, run_over = 0, exp_start = 0, model_on = 0;
  bit  e_to = 0, e_nk = 0, e_kept = 0;
  int  pops = 0, wstop_idx = -1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  // byte engine and device model, compared every clock
  initial begin
    forever begin
      @(negedge clk);
      bm_done = 1'b0;
      bm_nack = 1'b0;
      if (model_on) begin
        if (final_armed) begin
          final_armed = 0;
          chk(done == 1'b1, "R9 done pulse", done, 1);
          chk(timeout_err == e_to, "R7 timeout_err", timeout_err, e_to);
          chk(nack_err == e_nk, "R8 nack_err", nack_err, e_nk);
          chk(bus_kept == e_kept, "R6 bus_kept", bus_kept, e_kept);
          run_over = 1;
        end else if (done) begin
          chk(1'b0, "R9 unexpected done", done, 0);
        end
        if (exp_start) begin
          exp_start = 0;
          chk(cmd_valid && cmd_op == 2'd0, "R3 immediate poll start",
              {cmd_valid, cmd_op}, 3'b100);
        end
        if (cmd_valid) begin
          wcnt++;
          if (wcnt >= lat_g) begin
            logic [9:0] e;
            bit nk;
            wcnt = 0;
            nk = 0;
            if (expq.size() == 0) begin
              chk(1'b0, "R2 R4 extra command", {cmd_op, cmd_byte}, 0);
            end else begin
              e = expq.pop_front();
              if (in_poll)
                chk(cmd_op == e[9:8] && (e[9:8] != 2'd1 || cmd_byte == e[7:0]),
                    "R4 R5 poll command", {cmd_op, cmd_byte}, e);
              else
                chk(cmd_op == e[9:8] && (e[9:8] != 2'd1 || cmd_byte == e[7:0]),
                    "R2 R8 write command", {cmd_op, cmd_byte}, e);
              if (cmd_op == 2'd1) begin
                if (!in_poll) begin
                  nk = (wsend_n == wn_g);
                  wsend_n++;
                end else begin
                  nk = (poll_n < np_g);
                  poll_n++;
                end
              end
              if (pops == wstop_idx) begin
                in_poll = 1;
                exp_start = 1;
              end
              pops++;
              if (expq.size() == 0) final_armed = 1;
            end
            bm_done = 1'b1;
            bm_nack = nk;
          end
        end
      end
    end
  end

  task automatic run(input logic [6:0] d, input logic [15:0] a, input logic [7:0] w,
                     input int mp, input bit hb, input int np, input int wn,
                     input int lt, input bit poke, input string name);
    int guard;
    expq.delete();
    lat_g = lt; np_g = np; wn_g = wn;
    wcnt = 0; wsend_n = 0; poll_n = 0; pops = 0;
    in_poll = 0; run_over = 0; final_armed = 0; exp_start = 0;
    e_to = 0; e_nk = 0; e_kept = 0; wstop_idx = -1;
    // write frame (R2)
    begin
      logic [7:0] fr [4];
      fr[0] = {d, 1'b0}; fr[1] = a[15:8]; fr[2] = a[7:0]; fr[3] = w;
      expq.push_back({2'd0, 8'h00});
      for (int i = 0; i < 4; i++) begin
        expq.push_back({2'd1, fr[i]});
        if (wn == i) break;
      end
      expq.push_back({2'd2, 8'h00});
    end
    if (wn >= 0) begin
      e_nk = 1;
    end else begin
      wstop_idx = expq.size() - 1;
      for (int i = 0; i < 100000; i++) begin
        expq.push_back({2'd0, 8'h00});
        expq.push_back({2'd1, {d, 1'b0}});
        if (i < np) begin
          expq.push_back({2'd2, 8'h00});
          if (mp != 0 && i + 1 == mp) begin
            e_to = 1;
            break;
          end
        end else begin
          if (!hb) expq.push_back({2'd2, 8'h00});
          e_kept = hb;
          break;
        end
      end
    end
    @(negedge clk);
    dev_addr = d; mem_addr = a; wr_data = w; max_polls = 8'(mp); hold_bus = hb;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, {name, " R2 accepted"}, busy, 1);
    chk({timeout_err, nack_err, bus_kept} == 3'b000, {name, " R9 flags cleared"},
        {timeout_err, nack_err, bus_kept}, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      mem_addr = ~a; wr_data = ~w; max_polls = 8'd1; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk(busy == 1'b1, {name, " R10 still busy"}, busy, 1);
    end
    guard = 0;
    while (!run_over && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(run_over == 1'b1, {name, " R9 completion reached"}, run_over, 1);
    chk(expq.size() == 0, {name, " R2 sequence length"}, expq.size(), 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b0, {name, " R9 done single cycle"}, done, 0);
    chk({timeout_err, nack_err, bus_kept} == {e_to, e_nk, e_kept},
        {name, " R9 flags held"}, {timeout_err, nack_err, bus_kept}, {e_to, e_nk, e_kept});
    chk(busy == 1'b0 && cmd_valid == 1'b0, {name, " R10 idle after run"},
        {busy, cmd_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, cmd_valid, timeout_err, nack_err, bus_kept} == 6'b0,
        "R1 reset state", {busy, done, cmd_valid, timeout_err, nack_err, bus_kept}, 0);
    model_on = 1;
    // two busy polls then ack, stop at end (R2 R3 R4 R5 R6)
    run(7'h50, 16'h1234, 8'hA5, 4, 1'b0, 2, -1, 1, 1'b0, "basic");
    // immediate ack, keep bus (R6)
    run(7'h51, 16'hBEEF, 8'h3C, 1, 1'b1, 0, -1, 3, 1'b0, "hold");
    // device never ready: timeout after 3 polls (R7)
    run(7'h2A, 16'h0F0F, 8'h77, 3, 1'b0, 10, -1, 2, 1'b0, "timeout");
    // no limit: six busy polls then success (R7)
    run(7'h13, 16'h8001, 8'h00, 0, 1'b0, 6, -1, 1, 1'b0, "unlimited");
    // address low byte rejected (R8)
    run(7'h50, 16'hCAFE, 8'h11, 5, 1'b0, 2, 2, 1, 1'b0, "wrnack_addr");
    // control byte of the write rejected (R8)
    run(7'h7F, 16'h0000, 8'hFF, 5, 1'b1, 0, 0, 2, 1'b0, "wrnack_ctrl");
    // ack on the limit attempt, with a req while busy (R7 R10)
    run(7'h44, 16'h5AA5, 8'h96, 3, 1'b0, 2, -1, 2, 1'b1, "limit_edge");
    // back-to-back after a timeout, flags clear (R9)
    run(7'h45, 16'h0102, 8'h03, 2, 1'b0, 2, -1, 1, 1'b0, "timeout2");
    run(7'h46, 16'h0405, 8'h06, 2, 1'b1, 1, -1, 1, 1'b0, "recover");
    model_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule